// File: doc/BRIEF.md
# Bidirectional Open-Drain Bus Repeater

This block joins a device pin to one port of an internal switch fabric so that an open-drain signal can pass through in either direction, with no direction input. Each side presents a sensed line level and has a drive value and a drive enable. At rest both enables are off, and the external pull-ups hold both lines high. When one side is pulled low, that side becomes the owner and the block pulls the other side low. The copy stays low for as long as the owner holds its line low.

When the owner lets go, the block does not simply float the copy. It drives the copy high for `HOLD_CYCLES` clock cycles to speed up the rising edge, and then releases both sides. Both sensed inputs pass through a two-stage synchronizer. The block then ignores the low it causes on the side it drives, so its own echo cannot lock it up. If both sides fall in the same cycle, the pin side becomes the owner. A new low is only accepted once the block has gone back to rest.

Top module: `bidir_repeater`

## Requirements
- R1: While `rst` is high, and on the first clock after it, both `pad_en_o` and `fab_en_o` are 0.
- R2: In the rest state both enables are 0, so neither side is driven. A side is driven only while its enable is 1, at the level of its drive value (0 = low, 1 = high).
- R3: A low on `pad_sense_i` sets `fab_en_o`=1 and `fab_drive_o`=0. This happens on the third rising clock edge after the change: two synchronizer stages plus the state register. Only one side is ever enabled at a time.
- R4: A low on `fab_sense_i` in the rest state sets `pad_en_o`=1 and `pad_drive_o`=0, with the same three-edge latency.
- R5: The copied low stays in place for as long as the owning side stays low.
- R6: When the owning side returns high, the copy is driven high (enable 1, drive 1) for exactly `HOLD_CYCLES` cycles. Both enables then return to 0. A low drive is never dropped straight to float.
- R7: While one side owns the low, a low sensed on the side being driven has no effect on either output.
- R8: If both sense inputs go low in the same cycle, the pin side becomes the owner, so the fabric side is driven low.
- R9: A low that arrives during the high-drive period has no effect until the rest state is reached. If that low is still present then, it is taken up as a new transfer. A transfer starts only from the rest state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_sense_i | input | 1 | Sensed level of the pin-side line |
| fab_sense_i | input | 1 | Sensed level of the fabric-side line |
| pad_en_o | output | 1 | Pin-side drive enable |
| pad_drive_o | output | 1 | Pin-side drive value (0 low, 1 high) |
| fab_en_o | output | 1 | Fabric-side drive enable |
| fab_drive_o | output | 1 | Fabric-side drive value (0 low, 1 high) |

## Verification
The assertions check the output rules on every cycle:
- the quiet state after reset;
- only one side ever enabled;
- a low drive never dropping straight to float;
- each high-drive burst lasting exactly `HOLD_CYCLES` cycles;
- a new low transfer starting only from rest.

Some properties depend on the level on the wired lines, which the assertions do not see. These are shown only by the bench's scenarios:
- the three-edge latency;
- echo rejection;
- pin-side priority when both sides fall together;
- deferral of a low that arrives during the high drive.

In those scenarios the bench models the open-drain lines with pull-ups.

// File: rtl/rep_pkg.sv
package rep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PAD_OWN = 3'd1,  // pin side holds low, fabric copy driven low
    ST_FAB_OWN = 3'd2,  // fabric side holds low, pin copy driven low
    ST_FAB_HI  = 3'd3,  // fabric copy actively driven high
    ST_PAD_HI  = 3'd4   // pin copy actively driven high
  } rep_state_t;

  typedef struct packed {
    logic pad_en;
    logic pad_drv;
    logic fab_en;
    logic fab_drv;
  } rep_drive_t;

  function automatic rep_drive_t drive_of(rep_state_t s);
    rep_drive_t d;
    d = '0;
    case (s)
      ST_PAD_OWN: d.fab_en = 1'b1;
      ST_FAB_OWN: d.pad_en = 1'b1;
      ST_FAB_HI: begin
        d.fab_en  = 1'b1;
        d.fab_drv = 1'b1;
      end
      ST_PAD_HI: begin
        d.pad_en  = 1'b1;
        d.pad_drv = 1'b1;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rep_sync.sv
module rep_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RESET_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RESET_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rep_hold_timer.sv
module rep_hold_timer #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);

  localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= LOAD_VAL;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/rep_ctrl.sv
module rep_ctrl
  import rep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pad_low,
  input  logic       fab_low,
  input  logic       hold_done,
  output logic       hold_load,
  output rep_drive_t drv_q
);

  rep_state_t state_q, state_d;

  always_comb begin
    state_d   = state_q;
    hold_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        // pin side checked first: it wins a tie
        if (pad_low)      state_d = ST_PAD_OWN;
        else if (fab_low) state_d = ST_FAB_OWN;
      end
      ST_PAD_OWN: begin
        // fab_low is our own echo here and is not looked at
        if (!pad_low) begin
          state_d   = ST_FAB_HI;
          hold_load = 1'b1;
        end
      end
      ST_FAB_OWN: begin
        if (!fab_low) begin
          state_d   = ST_PAD_HI;
          hold_load = 1'b1;
        end
      end
      ST_FAB_HI, ST_PAD_HI: begin
        if (hold_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      drv_q   <= '0;
    end else begin
      state_q <= state_d;
      drv_q   <= drive_of(state_d);
    end
  end

endmodule

// File: rtl/bidir_repeater.sv
module bidir_repeater
  import rep_pkg::*;
#(
  parameter int HOLD_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_sense_i,
  input  logic fab_sense_i,
  output logic pad_en_o,
  output logic pad_drive_o,
  output logic fab_en_o,
  output logic fab_drive_o
);

  localparam int NSIDES = 2;

  logic [NSIDES-1:0] sense_raw, sense_s;
  logic              hold_load, hold_done;
  rep_drive_t        drv;

  assign sense_raw = {pad_sense_i, fab_sense_i};

  rep_sync #(
    .WIDTH    (NSIDES),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL({NSIDES{1'b1}})
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (sense_raw),
    .q  (sense_s)
  );

  rep_hold_timer #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .load(hold_load),
    .done(hold_done)
  );

  rep_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pad_low  (!sense_s[1]),
    .fab_low  (!sense_s[0]),
    .hold_done(hold_done),
    .hold_load(hold_load),
    .drv_q    (drv)
  );

  assign pad_en_o    = drv.pad_en;
  assign pad_drive_o = drv.pad_drv;
  assign fab_en_o    = drv.fab_en;
  assign fab_drive_o = drv.fab_drv;

endmodule

// File: rtl/bidir_repeater_chk.sv
module bidir_repeater_chk #(
  parameter int HOLD_CYCLES = 4
) (
  input logic clk,
  input logic rst,
  input logic pad_en_o,
  input logic pad_drive_o,
  input logic fab_en_o,
  input logic fab_drive_o
);

  logic        hi_now;
  logic [31:0] hi_run;

  assign hi_now = (pad_en_o && pad_drive_o) || (fab_en_o && fab_drive_o);

  always_ff @(posedge clk) begin
    if (rst)         hi_run <= '0;
    else if (hi_now) hi_run <= hi_run + 32'd1;
    else             hi_run <= '0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pad_en_o && !fab_en_o));

  assert_one_side_R3: assert property (@(posedge clk) disable iff (rst)
    !(pad_en_o && fab_en_o));

  assert_low_to_high_R6: assert property (@(posedge clk) disable iff (rst)
    (fab_en_o && !fab_drive_o) |=> fab_en_o);

  assert_pad_low_to_high_R6: assert property (@(posedge clk) disable iff (rst)
    (pad_en_o && !pad_drive_o) |=> pad_en_o);

  assert_hi_not_long_R6: assert property (@(posedge clk) disable iff (rst)
    hi_now |-> (hi_run < HOLD_CYCLES));

  assert_hi_length_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(hi_now) |-> (hi_run == HOLD_CYCLES));

  assert_pad_start_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pad_en_o && !pad_drive_o) |-> $past(!pad_en_o && !fab_en_o));

  assert_fab_start_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fab_en_o && !fab_drive_o) |-> $past(!pad_en_o && !fab_en_o));

endmodule

bind bidir_repeater bidir_repeater_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pad_en_o   (pad_en_o),
  .pad_drive_o(pad_drive_o),
  .fab_en_o   (fab_en_o),
  .fab_drive_o(fab_drive_o)
);

// File: tb/bidir_repeater_test.sv
module bidir_repeater_test;

  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pad_low = 1'b0;
  logic ext_fab_low = 1'b0;
  logic pad_en, pad_drv, fab_en, fab_drv;

  // open-drain lines with pull-ups: low if anyone pulls low
  wire pad_line = !(ext_pad_low || (pad_en && !pad_drv));
  wire fab_line = !(ext_fab_low || (fab_en && !fab_drv));

  always #4 clk = ~clk;

  bidir_repeater #(.HOLD_CYCLES(HOLD)) uut (
    .clk        (clk),
    .rst        (rst),
    .pad_sense_i(pad_line),
    .fab_sense_i(fab_line),
    .pad_en_o   (pad_en),
    .pad_drive_o(pad_drv),
    .fab_en_o   (fab_en),
    .fab_drive_o(fab_drv)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: outputs {pad_en,pad_drv,fab_en,fab_drv} got %b expected %b at %0t",
               req, got, exp, $time);
    end
  endtask

  // behavioural reference: 0 rest, 1 pin owns, 2 fabric owns, 3 fabric high, 4 pin high
  int         m_mode = 0;
  int         m_cnt  = 0;
  logic [1:0] lineq[$];
  logic [1:0] head;

  function automatic logic [3:0] m_out(int mode);
    case (mode)
      1:       return 4'b0010;
      2:       return 4'b1000;
      3:       return 4'b0011;
      4:       return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0;
      m_cnt  = 0;
      lineq.delete();
      lineq.push_back(2'b11);
      lineq.push_back(2'b11);
    end else begin
      head = lineq.pop_front();
      case (m_mode)
        0: begin
          if (!head[1])      m_mode = 1;
          else if (!head[0]) m_mode = 2;
        end
        1: if (head[1]) begin m_mode = 3; m_cnt = HOLD; end
        2: if (head[0]) begin m_mode = 4; m_cnt = HOLD; end
        default: begin
          m_cnt--;
          if (m_cnt == 0) m_mode = 0;
        end
      endcase
      lineq.push_back({pad_line, fab_line});
    end
  end

  always @(posedge clk) begin
    #2;
    if (!rst) check(cur_req, {pad_en, pad_drv, fab_en, fab_drv}, m_out(m_mode));
  end

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {pad_en, pad_drv, fab_en, fab_drv};
  endfunction

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset
    waitn(3);
    check("R1", outs(), 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1", outs(), 4'b0000);

    // R2 rest
    cur_req = "R2";
    waitn(6);
    check("R2", outs(), 4'b0000);

    // R3 pin low copied to fabric after three edges
    cur_req = "R3";
    ext_pad_low = 1'b1;
    waitn(2);
    check("R3", outs(), 4'b0000);
    waitn(1);
    check("R3", outs(), 4'b0010);
    cur_req = "R5";
    waitn(8);
    check("R5", outs(), 4'b0010);

    // R6 release: fabric driven high for HOLD cycles
    cur_req = "R6";
    ext_pad_low = 1'b0;
    waitn(3);
    check("R6", outs(), 4'b0011);
    waitn(HOLD - 1);
    check("R6", outs(), 4'b0011);
    waitn(1);
    check("R6", outs(), 4'b0000);
    waitn(4);

    // R4 fabric low copied to pin
    cur_req = "R4";
    ext_fab_low = 1'b1;
    waitn(3);
    check("R4", outs(), 4'b1000);
    waitn(5);
    check("R5", outs(), 4'b1000);
    cur_req = "R6";
    ext_fab_low = 1'b0;
    waitn(3);
    check("R6", outs(), 4'b1100);
    waitn(HOLD);
    check("R6", outs(), 4'b0000);
    waitn(3);

    // R7 low on the driven side while pin owns
    cur_req = "R7";
    ext_pad_low = 1'b1;
    waitn(4);
    ext_fab_low = 1'b1;
    waitn(6);
    check("R7", outs(), 4'b0010);
    ext_fab_low = 1'b0;
    waitn(4);
    check("R7", outs(), 4'b0010);
    ext_pad_low = 1'b0;
    waitn(12);
    check("R7", outs(), 4'b0000);

    // R8 both fall together: pin side wins
    cur_req = "R8";
    ext_pad_low = 1'b1;
    ext_fab_low = 1'b1;
    waitn(3);
    check("R8", outs(), 4'b0010);
    waitn(3);
    ext_pad_low = 1'b0;
    ext_fab_low = 1'b0;
    waitn(12);
    check("R8", outs(), 4'b0000);

    // R9 low arriving during the high drive is deferred to rest
    cur_req = "R9";
    ext_pad_low = 1'b1;
    waitn(5);
    ext_pad_low = 1'b0;
    waitn(4);
    check("R9", outs(), 4'b0011);
    ext_fab_low = 1'b1;
    waitn(1);
    check("R9", outs(), 4'b0011);
    waitn(1);
    check("R9", outs(), 4'b0011);
    waitn(1);
    check("R9", outs(), 4'b0000);
    waitn(1);
    check("R9", outs(), 4'b1000);
    ext_fab_low = 1'b0;
    waitn(12);
    check("R9", outs(), 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule